// File: doc/BRIEF.md
# Two-Master Spoke Crossbar

This block connects two bus masters, a processor port and a DMA port, to peripherals spread over eight independent spokes. Each master offers one transaction at a time. A transaction carries an address, a read/write flag, a size code and byte-lane-aligned write data. The top bits of the address pick the spoke. The request is routed to that spoke's peripheral, and the peripheral's response comes back on the requesting master's ready, error and read-data outputs.

Masters that target different spokes proceed in the same cycles, with no effect on each other. When both masters want the same spoke on the same edge, a round-robin arbiter belonging to that spoke chooses one of them. The other master simply sees ready stay low until its turn comes. A granted spoke stays locked to its owner until the peripheral answers. Spoke 5 has no peripheral. Any access decoded there gets an error response at once.

The peripheral on each spoke is a register bank with byte-lane write enables and a configurable number of wait cycles. A master asserts its request and holds every request input stable until it sees ready. If the request is still high on the edge after ready, that is a new transaction.

Top module: `dual_master_xbar`

## Requirements
- R1: While reset is high and on the first cycle after it, both masters see ready, error and read data all zero.
- R2: Address bits [ADDR_W-1:ADDR_W-3] select the spoke. Bits [2 +: log2(DEPTH)] select the word within the spoke's bank. Address bits between those two fields are ignored. Each spoke has its own storage, so the same word index on two spokes holds two independent values.
- R3: Take a request sampled on edge n by an idle spoke that no one else wants. Its master sees ready high for exactly one cycle after edge n+WAIT_CYC+1, with error low.
- R4: When the processor and the DMA target different spokes on the same edge, both are served with the R3 latency and their ready pulses coincide.
- R5: When both masters request the same idle spoke on the same edge, the master not granted most recently on that spoke wins. After reset the processor wins the first tie. The loser is taken on the edge after the winner's ready edge.
- R6: While a spoke is serving one master, a request from the other master to that spoke is not accepted until the first transaction's ready edge has passed.
- R7: A request decoded to spoke 5 produces ready and error high for one cycle after the edge that sampled it, with read data zero. It changes no storage on any spoke.
- R8: The size code k (0..3) enables k+1 byte lanes starting at lane addr[1:0]. Lanes beyond lane 3 are dropped. Byte i of the write data is lane i, and only enabled lanes are written.
- R9: A read returns the stored bytes on enabled lanes and zero on all other lanes. A completed write returns read data zero.
- R10: A master that keeps its request high on the edge after its ready cycle starts a new transaction on that edge, with the usual latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request valid, held until ready |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_size | input | 2 | Processor size code, bytes minus one |
| cpu_wdata | input | DATA_W | Processor write data, lane aligned |
| cpu_ready | output | 1 | Processor transaction complete |
| cpu_err | output | 1 | Processor decode error, valid with ready |
| cpu_rdata | output | DATA_W | Processor read data, valid with ready |
| dma_req | input | 1 | DMA request valid, held until ready |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | ADDR_W | DMA byte address |
| dma_size | input | 2 | DMA size code, bytes minus one |
| dma_wdata | input | DATA_W | DMA write data, lane aligned |
| dma_ready | output | 1 | DMA transaction complete |
| dma_err | output | 1 | DMA decode error, valid with ready |
| dma_rdata | output | DATA_W | DMA read data, valid with ready |

## Verification
Each issued transaction gets a due cycle, computed from the requirements and stored beside its expected error flag and data. A spoke access is due WAIT_CYC+1 edges after its sampling edge, and a reserved-spoke access on the sampling edge itself. A tie loser waits a further WAIT_CYC+2 edges, and a request that arrives while the spoke is locked waits until one edge after the owner's ready edge. The monitor compares at the falling edge, so it sees ready in the cycle it is due. A ready that comes early or late fails its check against that cycle number, as does a missing ready, which fails once the due cycle has passed.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int NUM_MST = 2;

  typedef enum logic [0:0] {
    MST_CPU = 1'b0,
    MST_DMA = 1'b1
  } mst_id_e;

  typedef enum logic [1:0] {
    XSZ_8  = 2'd0,
    XSZ_16 = 2'd1,
    XSZ_24 = 2'd2,
    XSZ_32 = 2'd3
  } xfer_size_e;
endpackage

// File: rtl/dmx_addr_dec.sv
module dmx_addr_dec #(
  parameter int ADDR_W    = 16,
  parameter int N_SPOKE   = 8,
  parameter int RSV_SPOKE = 5,
  parameter int DEPTH     = 16,
  parameter int LANES     = 4,
  localparam int SPK_W    = $clog2(N_SPOKE),
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int OFF_W    = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [SPK_W-1:0]  spoke,
  output logic [IDX_W-1:0]  widx,
  output logic [LANES-1:0]  be,
  output logic              rsv
);
  logic unused_mid_bits;
  assign unused_mid_bits = ^addr[ADDR_W-SPK_W-1:OFF_W+IDX_W];

  always_comb begin
    spoke = addr[ADDR_W-1 -: SPK_W];
    widx  = addr[OFF_W +: IDX_W];
    rsv   = (spoke == SPK_W'(RSV_SPOKE));
    for (int i = 0; i < LANES; i++) begin
      be[i] = (i >= int'(addr[OFF_W-1:0])) &&
              (i <= int'(addr[OFF_W-1:0]) + int'(size));
    end
  end
endmodule

// File: rtl/dmx_rr_pick.sv
module dmx_rr_pick
  import dmx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_MST-1:0] req,
  input  logic               idle,
  output logic               take,
  output mst_id_e            pick
);
  mst_id_e last_q;

  always_comb begin
    take = idle && (|req);
    if (req[MST_DMA] && (!req[MST_CPU] || last_q == MST_CPU)) pick = MST_DMA;
    else pick = MST_CPU;
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= MST_DMA;
    else if (take) last_q <= pick;
  end
endmodule

// File: rtl/dmx_spoke_bank.sv
module dmx_spoke_bank
  import dmx_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 16,
  parameter int WAIT_CYC = 1,
  localparam int LANES   = DATA_W / 8,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mst_id_e           start_id,
  input  logic              start_we,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [LANES-1:0]  start_be,
  input  logic [DATA_W-1:0] start_wdata,
  output logic              busy,
  output logic              done,
  output mst_id_e           done_id,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              busy_q, done_q, we_q;
  logic [CNT_W-1:0]  cnt_q;
  mst_id_e           id_q;
  logic              cmd_we;
  logic [IDX_W-1:0]  cmd_idx;
  logic [LANES-1:0]  cmd_be, be_q;
  logic [DATA_W-1:0] cmd_wd, rd_raw, lane_mask;
  logic              fire;

  assign fire = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= fire;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(WAIT_CYC);
      end else if (fire) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (start && !busy_q) begin
      id_q    <= start_id;
      cmd_we  <= start_we;
      cmd_idx <= start_idx;
      cmd_be  <= start_be;
      cmd_wd  <= start_wdata;
    end
    if (fire) begin
      we_q <= cmd_we;
      be_q <= cmd_be;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      if (cmd_we) begin
        for (int i = 0; i < LANES; i++) begin
          if (cmd_be[i]) mem[cmd_idx][8*i +: 8] <= cmd_wd[8*i +: 8];
        end
      end
      rd_raw <= mem[cmd_idx];
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) lane_mask[8*i +: 8] = {8{be_q[i]}};
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign done_id = id_q;
  assign rdata   = (done_q && !we_q) ? (rd_raw & lane_mask) : '0;
endmodule

// File: rtl/dual_master_xbar.sv
module dual_master_xbar
  import dmx_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int N_SPOKE   = 8,
  parameter int RSV_SPOKE = 5,
  parameter int DEPTH     = 16,
  parameter int WAIT_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_err,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              dma_req,
  input  logic              dma_we,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [1:0]        dma_size,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              dma_ready,
  output logic              dma_err,
  output logic [DATA_W-1:0] dma_rdata
);
  localparam int LANES = DATA_W / 8;
  localparam int SPK_W = $clog2(N_SPOKE);
  localparam int IDX_W = $clog2(DEPTH);

  logic              m_req   [NUM_MST];
  logic              m_we    [NUM_MST];
  logic [ADDR_W-1:0] m_addr  [NUM_MST];
  logic [1:0]        m_size  [NUM_MST];
  logic [DATA_W-1:0] m_wdata [NUM_MST];
  logic [SPK_W-1:0]  m_spoke [NUM_MST];
  logic [IDX_W-1:0]  m_widx  [NUM_MST];
  logic [LANES-1:0]  m_be    [NUM_MST];
  logic              m_rsv   [NUM_MST];
  logic              m_ready [NUM_MST];
  logic [DATA_W-1:0] m_rdata [NUM_MST];
  logic [NUM_MST-1:0] err_q;

  logic [N_SPOKE-1:0] s_done;
  mst_id_e            s_id    [N_SPOKE];
  logic [DATA_W-1:0]  s_rdata [N_SPOKE];

  assign m_req[MST_CPU]   = cpu_req;
  assign m_we[MST_CPU]    = cpu_we;
  assign m_addr[MST_CPU]  = cpu_addr;
  assign m_size[MST_CPU]  = cpu_size;
  assign m_wdata[MST_CPU] = cpu_wdata;
  assign m_req[MST_DMA]   = dma_req;
  assign m_we[MST_DMA]    = dma_we;
  assign m_addr[MST_DMA]  = dma_addr;
  assign m_size[MST_DMA]  = dma_size;
  assign m_wdata[MST_DMA] = dma_wdata;

  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    dmx_addr_dec #(
      .ADDR_W(ADDR_W), .N_SPOKE(N_SPOKE), .RSV_SPOKE(RSV_SPOKE),
      .DEPTH(DEPTH), .LANES(LANES)
    ) u_dec (
      .addr(m_addr[m]), .size(m_size[m]), .spoke(m_spoke[m]),
      .widx(m_widx[m]), .be(m_be[m]), .rsv(m_rsv[m])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else begin
      for (int m = 0; m < NUM_MST; m++) err_q[m] <= m_req[m] && m_rsv[m];
    end
  end

  for (genvar s = 0; s < N_SPOKE; s++) begin : g_spk
    if (s == RSV_SPOKE) begin : g_hole
      assign s_done[s]  = 1'b0;
      assign s_id[s]    = MST_CPU;
      assign s_rdata[s] = '0;
    end else begin : g_bank
      logic [NUM_MST-1:0] sreq;
      logic               take, busy;
      mst_id_e            pick;

      always_comb begin
        for (int m = 0; m < NUM_MST; m++) begin
          sreq[m] = m_req[m] && !m_rsv[m] && (m_spoke[m] == SPK_W'(s));
        end
      end

      dmx_rr_pick u_arb (
        .clk(clk), .rst(rst), .req(sreq), .idle(!busy),
        .take(take), .pick(pick)
      );

      dmx_spoke_bank #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .WAIT_CYC(WAIT_CYC)
      ) u_bank (
        .clk(clk), .rst(rst),
        .start(take), .start_id(pick),
        .start_we(m_we[pick]), .start_idx(m_widx[pick]),
        .start_be(m_be[pick]), .start_wdata(m_wdata[pick]),
        .busy(busy), .done(s_done[s]), .done_id(s_id[s]),
        .rdata(s_rdata[s])
      );
    end
  end

  always_comb begin
    for (int m = 0; m < NUM_MST; m++) begin
      m_ready[m] = err_q[m];
      m_rdata[m] = '0;
      for (int s = 0; s < N_SPOKE; s++) begin
        if (s_done[s] && s_id[s] == mst_id_e'(m)) begin
          m_ready[m] = 1'b1;
          m_rdata[m] = m_rdata[m] | s_rdata[s];
        end
      end
    end
  end

  assign cpu_ready = m_ready[MST_CPU];
  assign cpu_err   = err_q[MST_CPU];
  assign cpu_rdata = m_rdata[MST_CPU];
  assign dma_ready = m_ready[MST_DMA];
  assign dma_err   = err_q[MST_DMA];
  assign dma_rdata = m_rdata[MST_DMA];
endmodule

// File: rtl/dual_master_xbar_chk.sv
module dual_master_xbar_chk #(
  parameter int DATA_W    = 32,
  parameter int N_SPOKE   = 8,
  parameter int RSV_SPOKE = 5,
  localparam int SPK_W    = $clog2(N_SPOKE)
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic [SPK_W-1:0]  cpu_spk,
  input logic              cpu_ready,
  input logic              cpu_err,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              dma_req,
  input logic [SPK_W-1:0]  dma_spk,
  input logic              dma_ready,
  input logic              dma_err,
  input logic [DATA_W-1:0] dma_rdata
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!cpu_ready && !dma_ready && !cpu_err && !dma_err));

  assert_cpu_ready_after_req_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> $past(cpu_req));

  assert_dma_ready_after_req_R3: assert property (@(posedge clk) disable iff (rst)
    dma_ready |-> $past(dma_req));

  assert_cpu_hole_errors_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cpu_req) && $past(cpu_spk) == SPK_W'(RSV_SPOKE))
      |-> (cpu_ready && cpu_err));

  assert_dma_hole_errors_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dma_req) && $past(dma_spk) == SPK_W'(RSV_SPOKE))
      |-> (dma_ready && dma_err));

  assert_cpu_err_source_R7: assert property (@(posedge clk) disable iff (rst)
    cpu_err |-> (cpu_ready && cpu_rdata == '0 && $past(cpu_spk) == SPK_W'(RSV_SPOKE)));

  assert_dma_err_source_R7: assert property (@(posedge clk) disable iff (rst)
    dma_err |-> (dma_ready && dma_rdata == '0 && $past(dma_spk) == SPK_W'(RSV_SPOKE)));
endmodule

bind dual_master_xbar dual_master_xbar_chk #(
  .DATA_W(DATA_W), .N_SPOKE(N_SPOKE), .RSV_SPOKE(RSV_SPOKE)
) u_chk (
  .clk(clk), .rst(rst),
  .cpu_req(cpu_req), .cpu_spk(cpu_addr[ADDR_W-1 -: $clog2(N_SPOKE)]),
  .cpu_ready(cpu_ready), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
  .dma_req(dma_req), .dma_spk(dma_addr[ADDR_W-1 -: $clog2(N_SPOKE)]),
  .dma_ready(dma_ready), .dma_err(dma_err), .dma_rdata(dma_rdata)
);

// File: tb/dual_master_xbar_tb.sv
`timescale 1ns/1ps
module dual_master_xbar_tb;
  localparam int WAIT = 1;
  localparam int RSV  = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 0, cpu_we = 0, dma_req = 0, dma_we = 0;
  logic [15:0] cpu_addr = '0, dma_addr = '0;
  logic [1:0]  cpu_size = '0, dma_size = '0;
  logic [31:0] cpu_wdata = '0, dma_wdata = '0;
  logic        cpu_ready, cpu_err, dma_ready, dma_err;
  logic [31:0] cpu_rdata, dma_rdata;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit ended = 0;

  logic [32:0] eq [2][$];
  int          cq [2][$];
  string       tq [2][$];
  logic [31:0] ref_mem [8][16];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_master_xbar #(
    .ADDR_W(16), .DATA_W(32), .N_SPOKE(8), .RSV_SPOKE(RSV), .DEPTH(16), .WAIT_CYC(WAIT)
  ) u_dut (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
    .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_size(dma_size),
    .dma_wdata(dma_wdata), .dma_ready(dma_ready), .dma_err(dma_err), .dma_rdata(dma_rdata)
  );

  function automatic logic [15:0] mk(int s, int idx, int off);
    return 16'((s << 13) | (idx << 2) | off);
  endfunction

  // Monitor: pops the expected item for each master when its ready shows.
  always @(negedge clk) begin
    if (!rst) begin
      for (int m = 0; m < 2; m++) begin
        logic        rdy;
        logic [32:0] act;
        rdy = (m == 0) ? cpu_ready : dma_ready;
        act = (m == 0) ? {cpu_err, cpu_rdata} : {dma_err, dma_rdata};
        if (rdy) begin
          checks++;
          if (cq[m].size() == 0) begin
            bad++;
            $display("FAIL R3 master %0d unexpected ready at cycle %0d act=%h exp=none", m, cyc, act);
          end else begin
            logic [32:0] ex;
            int          due;
            string       tg;
            ex = eq[m].pop_front();
            due = cq[m].pop_front();
            tg = tq[m].pop_front();
            if (act !== ex || cyc != due) begin
              bad++;
              $display("FAIL %s master %0d act=%h@%0d exp=%h@%0d", tg, m, act, cyc, ex, due);
            end
          end
        end else if (cq[m].size() > 0 && cyc > cq[m][0]) begin
          checks++;
          bad++;
          $display("FAIL %s master %0d no ready by cycle %0d act=none exp=%h@%0d",
                   tq[m][0], m, cyc, eq[m][0], cq[m][0]);
          void'(eq[m].pop_front());
          void'(cq[m].pop_front());
          void'(tq[m].pop_front());
        end
      end
    end
  end

  // Driver: computes the expected response and its due cycle, then runs the request.
  task automatic xfer(input int m, input bit we, input logic [15:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, input int extra, input string tag);
    int sp, idx, off, lat;
    logic [31:0] lm, ed;
    logic ee;
    sp = int'(a[15:13]);
    idx = int'(a[5:2]);
    off = int'(a[1:0]);
    lm = '0;
    for (int i = 0; i < 4; i++) if (i >= off && i <= off + int'(sz)) lm[8*i +: 8] = 8'hFF;
    ee = 1'b0;
    ed = '0;
    if (sp == RSV) lat = 0;
    else lat = WAIT + 1 + extra;
    if (sp == RSV) ee = 1'b1;
    else if (we) ref_mem[sp][idx] = (ref_mem[sp][idx] & ~lm) | (wd & lm);
    else ed = ref_mem[sp][idx] & lm;
    eq[m].push_back({ee, ed});
    cq[m].push_back(cyc + 1 + lat);
    tq[m].push_back(tag);
    if (m == 0) begin
      cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
    end else begin
      dma_req = 1; dma_we = we; dma_addr = a; dma_size = sz; dma_wdata = wd;
    end
    do begin
      @(negedge clk);
      #1;
    end while (!((m == 0) ? cpu_ready : dma_ready));
    if (m == 0) cpu_req = 0;
    else dma_req = 0;
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (cpu_ready || cpu_err || cpu_rdata != 0) begin
      bad++;
      $display("FAIL R1 cpu in reset act=%b%b%h exp=000", cpu_ready, cpu_err, cpu_rdata);
    end
    rst = 0;
    @(negedge clk);
    #1;
    checks++;
    if (dma_ready || dma_err || dma_rdata != 0 || cpu_ready || cpu_err) begin
      bad++;
      $display("FAIL R1 after reset act=%b%b%h exp=000", dma_ready, dma_err, dma_rdata);
    end

    // R2 / R10: independent storage per spoke, back-to-back on one master
    xfer(0, 1, mk(0, 3, 0), 2'd3, 32'hA0A0A0A0, 0, "R2");
    xfer(0, 1, mk(1, 3, 0), 2'd3, 32'hB1B1B1B1, 0, "R2");
    xfer(0, 1, mk(4, 3, 0), 2'd3, 32'h44444444, 0, "R2");
    xfer(0, 1, mk(6, 3, 0), 2'd3, 32'h66666666, 0, "R2");
    xfer(0, 0, mk(0, 3, 0), 2'd3, 32'h0, 0, "R2");
    xfer(0, 0, mk(1, 3, 0), 2'd3, 32'h0, 0, "R2");
    xfer(1, 0, mk(0, 3, 0) | 16'h0140, 2'd3, 32'h0, 0, "R2");
    xfer(1, 1, mk(1, 9, 0), 2'd3, 32'h0BADF00D, 0, "R10");
    xfer(1, 0, mk(1, 9, 0), 2'd3, 32'h0, 0, "R10");

    // R4: parallel access to different spokes
    fork
      xfer(0, 1, mk(2, 0, 0), 2'd3, 32'h22220000, 0, "R4");
      xfer(1, 1, mk(3, 0, 0), 2'd3, 32'h33330000, 0, "R4");
    join
    fork
      xfer(0, 0, mk(3, 0, 0), 2'd3, 32'h0, 0, "R4");
      xfer(1, 0, mk(2, 0, 0), 2'd3, 32'h0, 0, "R4");
    join

    // R5: ties on one spoke
    fork
      xfer(0, 1, mk(7, 1, 0), 2'd3, 32'h71717171, 0, "R5");
      xfer(1, 1, mk(7, 2, 0), 2'd3, 32'h72727272, WAIT + 2, "R5");
    join
    fork
      xfer(0, 0, mk(7, 1, 0), 2'd3, 32'h0, 0, "R5");
      xfer(1, 0, mk(7, 2, 0), 2'd3, 32'h0, WAIT + 2, "R5");
    join
    xfer(0, 0, mk(7, 1, 0), 2'd3, 32'h0, 0, "R5");
    fork
      xfer(0, 0, mk(7, 2, 0), 2'd3, 32'h0, WAIT + 2, "R5");
      xfer(1, 0, mk(7, 1, 0), 2'd3, 32'h0, 0, "R5");
    join

    // R6: late request to a locked spoke waits for the owner
    fork
      xfer(0, 1, mk(6, 5, 0), 2'd3, 32'h65656565, 0, "R6");
      begin
        @(negedge clk);
        #1;
        xfer(1, 0, mk(6, 3, 0), 2'd3, 32'h0, WAIT + 1, "R6");
      end
    join

    // R8 / R9: byte lanes
    xfer(0, 1, mk(2, 3, 0), 2'd3, 32'h11223344, 0, "R8");
    xfer(0, 1, mk(2, 3, 2), 2'd0, 32'hFFAAFFFF, 0, "R8");
    xfer(0, 1, mk(2, 3, 3), 2'd1, 32'hBBCCDDEE, 0, "R8");
    xfer(1, 0, mk(2, 3, 0), 2'd3, 32'h0, 0, "R8");
    xfer(1, 0, mk(2, 3, 1), 2'd1, 32'h0, 0, "R9");
    xfer(1, 0, mk(2, 3, 2), 2'd3, 32'h0, 0, "R9");
    xfer(1, 0, mk(2, 3, 0), 2'd0, 32'h0, 0, "R9");
    xfer(1, 0, mk(2, 3, 1), 2'd2, 32'h0, 0, "R9");

    // R7: reserved spoke
    xfer(0, 1, mk(5, 3, 0), 2'd3, 32'hDEADBEEF, 0, "R7");
    xfer(0, 1, mk(5, 3, 0), 2'd3, 32'hCAFEF00D, 0, "R7");
    xfer(1, 0, mk(5, 3, 0), 2'd3, 32'h0, 0, "R7");
    xfer(0, 0, mk(4, 3, 0), 2'd3, 32'h0, 0, "R7");
    xfer(1, 0, mk(6, 3, 0), 2'd3, 32'h0, 0, "R7");

    repeat (4) @(negedge clk);
    checks++;
    if (cq[0].size() != 0 || cq[1].size() != 0) begin
      bad++;
      $display("FAIL R3 leftover items act=%0d exp=0", cq[0].size() + cq[1].size());
    end
    summary();
  end
endmodule